// File: doc/BRIEF.md
# DMA event and interrupt router

This block keeps the shared event-interrupt resources of a multi-channel DMA engine. There are `NUM_EVT` numbered resources and one extra abort resource, which sits at index `NUM_EVT`. Channel threads and a register-interface command can each issue a send request that names a numbered resource. The abort resource is set only by the abort input, which the engine's fault logic drives.

A mode mask holds one bit per resource. When a resource's bit is 0, the resource is an event. A send then marks the event pending, and every thread can see it. A thread that waits on that resource consumes the event and is released. When the bit is 1, the resource is an interrupt. A send then drives its interrupt output high, and the output stays high until software clears it.

Software reaches the block through a small register interface. It can read and write the mode mask, read the raw status and the interrupt status, clear interrupts by writing ones, and issue send commands.

Top module: `dma_evt_router`

## Requirements
- R1: While `rst` is high at a rising edge, every resource becomes inactive and the mode mask becomes all zeros (event mode). After that edge, `irq_o`, `thr_wfe_done`, `sev_err` and `reg_rdata` read 0.
- R2: A send to resource n in event mode marks event n pending. From the next cycle, bit n of the raw status reads 1. `irq_o[n]` stays 0.
- R3: A send to resource n in interrupt mode sets `irq_o[n]` high at the next edge. It stays high until a clear write removes it.
- R4: If thread t asserts `thr_wfe_req[t]` with `thr_wfe_num` = n while event n is pending, `thr_wfe_done[t]` is high for one cycle after the next edge, and event n is no longer pending. All threads waiting on n in that cycle are released together.
- R5: A wait on an event that is not pending stalls, with no done. If a send and a wait for the same event-mode resource arrive in the same cycle, the waiter is released at the next edge and the event is not left pending.
- R6: A write to address 3 clears `irq_o[i]` for every data bit i that is 1 and whose resource is in interrupt mode. Bit 8 is the abort resource. For a resource in event mode the clear has no effect. A send to the same resource in the same cycle wins over the clear.
- R7: Reading address 1 (raw status) returns bit i = event i pending OR interrupt i high. Reading address 2 (interrupt status) returns only the interrupt lines.
- R8: A send whose number is NUM_EVT or more is rejected. That includes the abort index 8 and the codes 9 to 15. The rejected send changes no state, and `sev_err` pulses high after the next edge.
- R9: Writing the mode mask leaves pending events and high interrupt lines unchanged. A send in the same cycle as a mode write routes by the old mask.
- R10: `abort_req` sets the abort resource (index 8) by its own mode bit: as an event, or as `irq_o[8]`.
- R11: The register map is 0 = mode mask (read/write), 1 = raw status, 2 = interrupt status, 3 = clear (write-one-to-clear, reads 0), 4 = send command (number in `reg_wdata[3:0]`, reads 0). `reg_rdata` is loaded at the edge where `reg_rd` is high, with the state from before that edge. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| thr_sev_vld | input | NUM_THR | Per-thread send request |
| thr_sev_num | input | NUM_THR*NUM_W | Per-thread target resource number |
| thr_wfe_req | input | NUM_THR | Per-thread wait request |
| thr_wfe_num | input | NUM_THR*NUM_W | Per-thread awaited resource number |
| thr_wfe_done | output | NUM_THR | One-cycle release of a waiting thread |
| abort_req | input | 1 | Sets the abort resource |
| irq_o | output | NUM_EVT+1 | Interrupt lines, abort at the top index |
| sev_err | output | 1 | Pulse after a send with an invalid number |

## Verification
The bench uses the defaults: eight numbered resources, four threads, and a 4-bit number field. The 4-bit field makes the abort index and the unused codes 9 to 15 reachable as invalid sends. Four threads allow several waiters on one event, and a send and a wait from different threads in the same cycle. The 9-bit mask lets random traffic mix event-mode and interrupt-mode resources, including the abort bit, while sends, waits, clears and mode writes land together.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  typedef enum logic [2:0] {
    CSR_MODE = 3'd0,
    CSR_RAW  = 3'd1,
    CSR_IRQ  = 3'd2,
    CSR_CLR  = 3'd3,
    CSR_SEV  = 3'd4
  } csr_addr_e;

endpackage

// File: rtl/dma_evt_sev_decode.sv
module dma_evt_sev_decode #(
  parameter int NUM_EVT = 8,
  parameter int NUM_THR = 4,
  parameter int NUM_W   = 4
) (
  input  logic [NUM_THR-1:0]       thr_sev_vld,
  input  logic [NUM_THR*NUM_W-1:0] thr_sev_num,
  input  logic                     cmd_vld,
  input  logic [NUM_W-1:0]         cmd_num,
  input  logic                     abort_req,
  output logic [NUM_EVT:0]         set_vec,
  output logic                     bad_num
);
  localparam int FULL    = 2 ** NUM_W;
  localparam int NUM_SRC = NUM_THR + 1;

  logic [NUM_SRC-1:0]           src_vld;
  logic [NUM_SRC-1:0][NUM_W-1:0] src_num;
  logic [NUM_SRC-1:0][FULL-1:0]  src_dec;
  logic [FULL-1:0]               set_full;

  assign src_vld[NUM_THR] = cmd_vld;
  assign src_num[NUM_THR] = cmd_num;

  genvar s;
  generate
    for (s = 0; s < NUM_THR; s++) begin : g_thr
      assign src_vld[s] = thr_sev_vld[s];
      assign src_num[s] = thr_sev_num[s*NUM_W +: NUM_W];
    end
    for (s = 0; s < NUM_SRC; s++) begin : g_dec
      assign src_dec[s] = src_vld[s] ? (FULL'(1) << src_num[s]) : '0;
    end
  endgenerate

  always_comb begin
    set_full = '0;
    for (int i = 0; i < NUM_SRC; i++) set_full = set_full | src_dec[i];
  end

  // only numbered resources are legal send targets; the abort slot has its own input
  assign bad_num = |set_full[FULL-1:NUM_EVT];
  assign set_vec = {abort_req, set_full[NUM_EVT-1:0]};
endmodule

// File: rtl/dma_evt_wfe_match.sv
module dma_evt_wfe_match #(
  parameter int NUM_RES = 9,
  parameter int NUM_THR = 4,
  parameter int NUM_W   = 4
) (
  input  logic [NUM_THR-1:0]       wfe_req,
  input  logic [NUM_THR*NUM_W-1:0] wfe_num,
  input  logic [NUM_RES-1:0]       avail,
  output logic [NUM_THR-1:0]       hit,
  output logic [NUM_RES-1:0]       consume
);
  localparam int FULL = 2 ** NUM_W;

  logic [FULL-1:0] avail_x;
  assign avail_x = FULL'(avail);

  genvar t;
  generate
    for (t = 0; t < NUM_THR; t++) begin : g_thr
      assign hit[t] = wfe_req[t] & avail_x[wfe_num[t*NUM_W +: NUM_W]];
    end
  endgenerate

  always_comb begin
    consume = '0;
    for (int i = 0; i < NUM_THR; i++)
      for (int r = 0; r < NUM_RES; r++)
        if (hit[i] && wfe_num[i*NUM_W +: NUM_W] == NUM_W'(r)) consume[r] = 1'b1;
  end
endmodule

// File: rtl/dma_evt_csr.sv
module dma_evt_csr
  import dma_evt_pkg::*;
#(
  parameter int NUM_RES = 9,
  parameter int NUM_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_RES-1:0] evt_q,
  input  logic [NUM_RES-1:0] irq_q,
  output logic [NUM_RES-1:0] en_mask,
  output logic [NUM_RES-1:0] clr_vec,
  output logic               cmd_vld,
  output logic [NUM_W-1:0]   cmd_num,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_RES];

  logic wr_mode, wr_clr;
  assign wr_mode = reg_wr && (reg_addr == CSR_MODE);
  assign wr_clr  = reg_wr && (reg_addr == CSR_CLR);
  assign cmd_vld = reg_wr && (reg_addr == CSR_SEV);
  assign cmd_num = reg_wdata[NUM_W-1:0];

  // clear reaches only resources currently in interrupt mode
  assign clr_vec = wr_clr ? (reg_wdata[NUM_RES-1:0] & en_mask) : '0;

  always_ff @(posedge clk) begin
    if (rst) en_mask <= '0;
    else if (wr_mode) en_mask <= reg_wdata[NUM_RES-1:0];
  end

  logic [NUM_RES-1:0] rd_sel;
  always_comb begin
    case (reg_addr)
      CSR_MODE: rd_sel = en_mask;
      CSR_RAW:  rd_sel = evt_q | irq_q;
      CSR_IRQ:  rd_sel = irq_q;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= DATA_W'(rd_sel);
  end
endmodule

// File: rtl/dma_evt_router.sv
module dma_evt_router #(
  parameter int NUM_EVT = 8,
  parameter int NUM_THR = 4,
  parameter int DATA_W  = 32,
  localparam int NUM_RES = NUM_EVT + 1,
  localparam int NUM_W   = $clog2(NUM_RES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [2:0]               reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [NUM_THR-1:0]       thr_sev_vld,
  input  logic [NUM_THR*NUM_W-1:0] thr_sev_num,
  input  logic [NUM_THR-1:0]       thr_wfe_req,
  input  logic [NUM_THR*NUM_W-1:0] thr_wfe_num,
  output logic [NUM_THR-1:0]       thr_wfe_done,
  input  logic                     abort_req,
  output logic [NUM_RES-1:0]       irq_o,
  output logic                     sev_err
);
  logic [NUM_RES-1:0] evt_q, irq_q, en_mask, clr_vec, set_vec, consume;
  logic [NUM_RES-1:0] set_evt, set_irq, avail;
  logic [NUM_THR-1:0] hit;
  logic               cmd_vld, bad_num;
  logic [NUM_W-1:0]   cmd_num;

  dma_evt_csr #(.NUM_RES(NUM_RES), .NUM_W(NUM_W), .DATA_W(DATA_W)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_q(evt_q), .irq_q(irq_q), .en_mask(en_mask),
    .clr_vec(clr_vec), .cmd_vld(cmd_vld), .cmd_num(cmd_num), .reg_rdata(reg_rdata)
  );

  dma_evt_sev_decode #(.NUM_EVT(NUM_EVT), .NUM_THR(NUM_THR), .NUM_W(NUM_W)) u_dec (
    .thr_sev_vld(thr_sev_vld), .thr_sev_num(thr_sev_num), .cmd_vld(cmd_vld),
    .cmd_num(cmd_num), .abort_req(abort_req), .set_vec(set_vec), .bad_num(bad_num)
  );

  // mode bits in force before this edge steer the request
  assign set_evt = set_vec & ~en_mask;
  assign set_irq = set_vec & en_mask;
  assign avail   = evt_q | set_evt;

  dma_evt_wfe_match #(.NUM_RES(NUM_RES), .NUM_THR(NUM_THR), .NUM_W(NUM_W)) u_wfe (
    .wfe_req(thr_wfe_req), .wfe_num(thr_wfe_num), .avail(avail),
    .hit(hit), .consume(consume)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q        <= '0;
      irq_q        <= '0;
      thr_wfe_done <= '0;
      sev_err      <= 1'b0;
    end else begin
      evt_q        <= avail & ~consume;
      irq_q        <= (irq_q & ~clr_vec) | set_irq;
      thr_wfe_done <= hit;
      sev_err      <= bad_num;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_evt_router_chk.sv
module dma_evt_router_chk
  import dma_evt_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int NUM_THR = 4,
  parameter int NUM_W   = 4,
  localparam int NUM_RES = NUM_EVT + 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_wr,
  input logic [2:0]               reg_addr,
  input logic [NUM_RES-1:0]       wdata_lo,
  input logic [NUM_THR-1:0]       thr_sev_vld,
  input logic [NUM_THR*NUM_W-1:0] thr_sev_num,
  input logic [NUM_THR-1:0]       thr_wfe_req,
  input logic [NUM_THR-1:0]       thr_wfe_done,
  input logic [NUM_RES-1:0]       irq_o,
  input logic [NUM_RES-1:0]       en_mask,
  input logic                     sev_err
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && thr_wfe_done == '0 && !sev_err)); // R1

  genvar t, i;
  generate
    for (t = 0; t < NUM_THR; t++) begin : g_thr
      AST_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        thr_wfe_done[t] |-> $past(thr_wfe_req[t])); // R4
      AST_BAD_SEV_FLAG: assert property (@(posedge clk) disable iff (rst)
        (thr_sev_vld[t] && int'(thr_sev_num[t*NUM_W +: NUM_W]) >= NUM_EVT) |=> sev_err); // R8
    end
    for (i = 0; i < NUM_RES; i++) begin : g_res
      AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_o[i] && !(reg_wr && reg_addr == CSR_CLR && wdata_lo[i])) |=> irq_o[i]); // R3
      AST_CLR_EVT_NOOP: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == CSR_CLR && !en_mask[i] && irq_o[i]) |=> irq_o[i]); // R6
    end
  endgenerate
endmodule

bind dma_evt_router dma_evt_router_chk #(.NUM_EVT(NUM_EVT), .NUM_THR(NUM_THR), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wdata_lo(reg_wdata[NUM_RES-1:0]), .thr_sev_vld(thr_sev_vld), .thr_sev_num(thr_sev_num),
  .thr_wfe_req(thr_wfe_req), .thr_wfe_done(thr_wfe_done), .irq_o(irq_o),
  .en_mask(en_mask), .sev_err(sev_err)
);

// File: tb/dma_evt_router_test.sv
`timescale 1ns/1ps
module dma_evt_router_test;
  localparam int NE = 8;
  localparam int NT = 4;
  localparam int NR = NE + 1;
  localparam int NW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [NT-1:0] thr_sev_vld, thr_wfe_req, thr_wfe_done;
  logic [NT*NW-1:0] thr_sev_num, thr_wfe_num;
  logic abort_req;
  logic [NR-1:0] irq_o;
  logic sev_err;

  always #4 clk = ~clk;

  dma_evt_router #(.NUM_EVT(NE), .NUM_THR(NT), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .thr_sev_vld(thr_sev_vld),
    .thr_sev_num(thr_sev_num), .thr_wfe_req(thr_wfe_req), .thr_wfe_num(thr_wfe_num),
    .thr_wfe_done(thr_wfe_done), .abort_req(abort_req), .irq_o(irq_o), .sev_err(sev_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  logic [NR-1:0] m_en, m_evt, m_irq, m_en_n, m_evt_n, m_irq_n;
  logic [NT-1:0] exp_done, exp_done_n;
  logic exp_err, exp_err_n;
  logic [DW-1:0] exp_rd, exp_rd_n;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // expected next state, computed from the requirements
  task automatic model_step();
    logic [15:0] setf;
    logic [NR-1:0] set, se, si, av, cons, clr;
    logic [NT-1:0] dn;
    int n;
    if (rst) begin
      m_en_n = '0; m_evt_n = '0; m_irq_n = '0; exp_done_n = '0; exp_err_n = 1'b0; exp_rd_n = '0;
      return;
    end
    setf = '0;
    for (int t = 0; t < NT; t++)
      if (thr_sev_vld[t]) setf[thr_sev_num[t*NW +: NW]] = 1'b1;
    if (reg_wr && reg_addr == 3'd4) setf[reg_wdata[NW-1:0]] = 1'b1;
    exp_err_n = |setf[15:NE];
    set = {abort_req, setf[NE-1:0]};
    se = set & ~m_en;
    si = set & m_en;
    av = m_evt | se;
    cons = '0; dn = '0;
    for (int t = 0; t < NT; t++) begin
      n = int'(thr_wfe_num[t*NW +: NW]);
      if (thr_wfe_req[t] && n < NR) if (av[n]) begin dn[t] = 1'b1; cons[n] = 1'b1; end
    end
    clr = (reg_wr && reg_addr == 3'd3) ? (reg_wdata[NR-1:0] & m_en) : '0;
    m_en_n  = (reg_wr && reg_addr == 3'd0) ? reg_wdata[NR-1:0] : m_en;
    m_evt_n = av & ~cons;
    m_irq_n = (m_irq & ~clr) | si;
    exp_done_n = dn;
    exp_rd_n = exp_rd;
    if (reg_rd) begin
      case (reg_addr)
        3'd0: exp_rd_n = DW'(m_en);
        3'd1: exp_rd_n = DW'(m_evt | m_irq);
        3'd2: exp_rd_n = DW'(m_irq);
        default: exp_rd_n = '0;
      endcase
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    m_en = m_en_n; m_evt = m_evt_n; m_irq = m_irq_n;
    exp_done = exp_done_n; exp_err = exp_err_n; exp_rd = exp_rd_n;
    chk("R3 irq_o", DW'(irq_o), DW'(m_irq));
    chk("R4 wfe_done", DW'(thr_wfe_done), DW'(exp_done));
    chk("R8 sev_err", DW'(sev_err), DW'(exp_err));
    chk("R7 rdata", reg_rdata, exp_rd);
  endtask

  task automatic idle_in();
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    thr_sev_vld = 0; thr_sev_num = 0; thr_wfe_req = 0; thr_wfe_num = 0; abort_req = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    idle_in(); reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); idle_in();
  endtask

  task automatic rd(logic [2:0] a);
    idle_in(); reg_rd = 1; reg_addr = a; tick(); idle_in();
  endtask

  task automatic tsev(int t, int n);
    idle_in(); thr_sev_vld[t] = 1; thr_sev_num[t*NW +: NW] = NW'(n); tick(); idle_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = '0; m_evt = '0; m_irq = '0; exp_done = '0; exp_err = 0; exp_rd = '0;
    idle_in();
    rst = 1;
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    chk("R1 irq after reset", DW'(irq_o), 0);
    chk("R1 done after reset", DW'(thr_wfe_done), 0);
    rd(3'd0);
    chk("R1 mode mask after reset", reg_rdata, 0);

    // event mode send
    tsev(0, 3);
    rd(3'd1);
    chk("R2 raw bit3", DW'(reg_rdata[3]), 1);
    chk("R2 no irq", DW'(irq_o[3]), 0);
    rd(3'd2);
    chk("R7 irq status zero", reg_rdata, 0);

    // two waiters released together
    idle_in();
    thr_wfe_req = 4'b0011; thr_wfe_num = {4'd0, 4'd0, 4'd3, 4'd3};
    tick(); idle_in();
    chk("R4 both released", DW'(thr_wfe_done), 3);
    rd(3'd1);
    chk("R4 event consumed", DW'(reg_rdata[3]), 0);

    // stall, then same-cycle send and wait
    idle_in(); thr_wfe_req[2] = 1; thr_wfe_num[2*NW +: NW] = 4'd5;
    tick(); tick();
    chk("R5 stalled", DW'(thr_wfe_done[2]), 0);
    thr_sev_vld[1] = 1; thr_sev_num[1*NW +: NW] = 4'd5;
    tick(); idle_in();
    chk("R5 same-cycle release", DW'(thr_wfe_done[2]), 1);
    rd(3'd1);
    chk("R5 not pending", DW'(reg_rdata[5]), 0);

    // interrupt mode via register command
    wr(3'd0, 32'h104);
    rd(3'd0);
    chk("R11 mode readback", reg_rdata, 32'h104);
    wr(3'd4, 32'd2);
    chk("R3 irq2 set", DW'(irq_o[2]), 1);
    repeat (3) tick();
    chk("R3 irq2 sticky", DW'(irq_o[2]), 1);
    rd(3'd2);
    chk("R7 irq status bit2", reg_rdata, 32'h004);

    // clear: event-mode bit untouched
    tsev(3, 6);
    wr(3'd3, 32'h044);
    chk("R6 irq2 cleared", DW'(irq_o[2]), 0);
    rd(3'd1);
    chk("R6 event6 kept", DW'(reg_rdata[6]), 1);

    // abort resource
    idle_in(); abort_req = 1; tick(); idle_in();
    chk("R10 abort irq", DW'(irq_o[8]), 1);
    wr(3'd3, 32'h100);
    chk("R10 abort cleared", DW'(irq_o[8]), 0);
    wr(3'd0, 32'h004);
    idle_in(); abort_req = 1; tick(); idle_in();
    rd(3'd1);
    chk("R10 abort as event", DW'(reg_rdata[8]), 1);
    chk("R10 no abort irq", DW'(irq_o[8]), 0);

    // mode change keeps pending state
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h040);
    chk("R9 irq2 kept", DW'(irq_o[2]), 1);
    rd(3'd1);
    chk("R9 event6 kept", DW'(reg_rdata[6]), 1);
    wr(3'd3, 32'h004);
    chk("R6 clear in event mode ignored", DW'(irq_o[2]), 1);

    // invalid numbers
    rd(3'd1);
    begin
      logic [DW-1:0] raw_before;
      raw_before = reg_rdata;
      tsev(0, 8);
      chk("R8 abort index rejected", DW'(sev_err), 1);
      tsev(2, 12);
      chk("R8 code 12 rejected", DW'(sev_err), 1);
      wr(3'd4, 32'd9);
      chk("R8 cmd 9 rejected", DW'(sev_err), 1);
      rd(3'd1);
      chk("R8 raw unchanged", reg_rdata, raw_before);
    end
    wr(3'd3, 32'h1FF);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      idle_in();
      for (int t = 0; t < NT; t++) begin
        thr_sev_vld[t] = ($urandom % 6) == 0;
        thr_sev_num[t*NW +: NW] = NW'(($urandom % 8 == 0) ? $urandom % 16 : $urandom % NR);
        thr_wfe_req[t] = ($urandom % 3) == 0;
        thr_wfe_num[t*NW +: NW] = NW'($urandom % NR);
      end
      abort_req = ($urandom % 20) == 0;
      reg_rd = ($urandom % 3) == 0;
      reg_wr = ($urandom % 4) == 0;
      reg_addr = 3'($urandom % 5);
      reg_wdata = (reg_addr == 3'd4) ? DW'($urandom % 16) : DW'($urandom & 32'h1FF);
      tick();
    end
    idle_in();
    tick();
    finish_run();
  end
endmodule